// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be one shared clock or fully unrelated. Storage holds `DEPTH` words, where `DEPTH` is 256, 512, 1024, 2048 or 4096. A word enters on each rising write-clock edge with the write enable high, unless the buffer is full. Words leave in arrival order under the read clock and read enable. Read and write positions cross between the clock domains as Gray codes through a synchroniser chain of one or two flops, set by `SYNC_STAGES`. Full and the write-side counts are worked out in the write domain. Empty and the read-side count are worked out in the read domain.

While both resets are low, the `fwft_sel` input picks one of two read timings. In standard timing, a read request loads the next word onto `dout`. `ef_or` then means "empty" and `ff_ir` means "full". In fall-through timing, the oldest word is moved onto `dout` by itself. `ef_or` then means "output ready" and `ff_ir` means "input ready", so both senses are inverted.

Three extra status flags report the fill level: almost-empty, almost-full and half-full. The almost-empty and almost-full thresholds come from two offsets. These offsets reset to defaults and can be reloaded through a parallel strobe port on the write clock. `PROG_REG` selects whether these three flags are registered in their own domain or decoded directly from the pointers.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words are delivered on `dout` in the exact order they were accepted, with all 18 bits intact.
- R2: A write attempted while the buffer is full is dropped. It changes neither the stored words nor the count.
- R3: In standard timing, a read attempted while empty leaves `dout` and the read position unchanged.
- R4: In standard timing, once the flags have settled, `ef_or` is 1 exactly when no word is stored, and `ff_ir` is 1 exactly when `DEPTH` words are stored.
- R5: In fall-through timing, the first word written into an empty buffer appears on `dout` with no read request, and `ef_or` is 1 while `dout` holds a valid word. `ff_ir` is 1 while the storage array has room, so the buffer holds up to `DEPTH`+1 words including the one on `dout`.
- R6: The timing mode is taken from `fwft_sel` while the resets are low: 0 gives standard timing and 1 gives fall-through timing. The mode holds until the next reset.
- R7: `hf` is 1 when the storage count is greater than `DEPTH`/2. The storage count is the number of words in the array, which in fall-through timing excludes the word shown on `dout`.
- R8: `ae` is 1 when the storage count is less than or equal to the empty offset.
- R9: `af` is 1 when the storage count is greater than or equal to `DEPTH` minus the full offset.
- R10: After reset both offsets are 7 when `DEPTH` is 256, and 63 for larger depths. A write-clock edge with `ofs_ld`=1 loads `ofs_val` into the empty offset when `ofs_sel`=0, or into the full offset when `ofs_sel`=1.
- R11: Right after reset, `hf`=0, `af`=0 and `ae`=1. `ef_or` and `ff_ir` read 1 and 0 in standard timing, or 0 and 1 in fall-through timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side synchronous reset, active low |
| wen | input | 1 | Write request |
| din | input | 18 | Write data |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side synchronous reset, active low |
| ren | input | 1 | Read request |
| dout | output | 18 | Read data |
| fwft_sel | input | 1 | Timing-mode choice, sampled during reset |
| ofs_ld | input | 1 | Offset load strobe (write clock) |
| ofs_sel | input | 1 | Offset target: 0 empty offset, 1 full offset |
| ofs_val | input | log2(DEPTH) | Offset value to load |
| ef_or | output | 1 | Empty (standard) or output ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input ready (fall-through) |
| ae | output | 1 | Almost-empty flag |
| af | output | 1 | Almost-full flag |
| hf | output | 1 | Half-full flag |

## Verification
Random traffic with a write-heavy bias, then a read-heavy bias, is run in both timing modes. This shows ordering and pointer wrap-around separately from how the flags behave near empty and near full. Directed fills bring the count to one below and exactly at each threshold: the default offsets, loaded offsets, half depth and full capacity. This shows the off-by-one placement of each comparison. Forced writes at full and forced reads at empty, each followed by a complete drain, show whether a blocked access disturbed the storage or a pointer. A write into an empty buffer with no read request shows the fall-through path apart from the standard one.

// File: rtl/dcf_pkg.sv
// Shared constants and helpers for the dual-clock FIFO.
// Assumes depths are powers of two between 256 and 4096.
package dcf_pkg;
    localparam int DATA_W = 18;
    localparam logic OFS_SEL_EMPTY = 1'b0;
    localparam logic OFS_SEL_FULL  = 1'b1;

    // Reset value of both threshold offsets for a given depth.
    function automatic int dflt_offset(input int depth);
        return (depth == 256) ? 7 : 63;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
// Multi-bit synchroniser chain into a destination clock domain.
// Assumes the input is a Gray code, so at most one bit changes per source edge.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the source value through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
// Storage array: registered write port on the write clock, unregistered read port.
// Assumes the write side never writes a slot that has not yet been read out.
module dcf_mem #(
    parameter int AW = 8,
    parameter int W  = 18
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int WORDS = 1 << AW;
    logic [W-1:0] store [WORDS];

    // Capture an accepted word.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-domain control. It keeps the write pointer, works out full from the
// synchronised read pointer, and derives the half-full and almost-full flags.
// It also holds the two threshold offsets and latches the timing mode at reset.
// Assumes the offsets are changed only while the buffer is idle, because the
// empty offset is used directly by the read domain.
module dcf_wr_ctrl #(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit PROG_REG    = 1'b1
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wen,
    input  logic          fwft_sel,
    input  logic          ofs_ld,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    input  logic [AW:0]   rgray_in,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] ae_ofs,
    output logic          ff_ir,
    output logic          hf,
    output logic          af
);
    localparam int PW = AW + 1;
    localparam logic [AW:0]   DEPTH_P = PW'(1 << AW);
    localparam logic [AW:0]   HALF_P  = PW'(1 << (AW - 1));
    localparam logic [AW-1:0] DFLT    = AW'(dcf_pkg::dflt_offset(1 << AW));

    logic [AW:0]   wbin, rq, rbin_w, wcount, af_thr;
    logic [AW-1:0] af_ofs;
    logic          full, fwft_w, hf_c, af_c;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(wclk), .rst_n(wrst_n), .d(rgray_in), .q(rq)
    );

    assign full   = (wgray == {~rq[AW:AW-1], rq[AW-2:0]});
    assign we     = wen & ~full;
    assign waddr  = wbin[AW-1:0];
    assign rbin_w = g2b(rq);
    assign wcount = wbin - rbin_w;
    assign af_thr = DEPTH_P - {1'b0, af_ofs};
    assign hf_c   = wcount > HALF_P;
    assign af_c   = wcount >= af_thr;
    assign ff_ir  = fwft_w ? ~full : full;

    // Advance the write pointer on each accepted word.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin + 1'b1;
            wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
        end
    end

    // Latch the timing mode while reset is held.
    always_ff @(posedge wclk) begin
        if (!wrst_n) fwft_w <= fwft_sel;
    end

    // Threshold offsets: defaults at reset, parallel load otherwise.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            ae_ofs <= DFLT;
            af_ofs <= DFLT;
        end else if (ofs_ld) begin
            if (ofs_sel == dcf_pkg::OFS_SEL_FULL) af_ofs <= ofs_val;
            else                                  ae_ofs <= ofs_val;
        end
    end

    generate
        if (PROG_REG) begin : g_reg
            // Register the level flags in the write domain.
            always_ff @(posedge wclk) begin
                if (!wrst_n) begin
                    hf <= 1'b0;
                    af <= 1'b0;
                end else begin
                    hf <= hf_c;
                    af <= af_c;
                end
            end
        end else begin : g_comb
            assign hf = hf_c;
            assign af = af_c;
        end
    endgenerate

    assert_count_bound_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
        wcount <= DEPTH_P);
    assert_reset_flags_R11: assert property (@(posedge wclk) disable iff (!wrst_n)
        $rose(wrst_n) |-> (!full && !hf && !af));
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-domain control. It keeps the read pointer, works out empty from the
// synchronised write pointer, and drives the output word register. In
// fall-through timing it also keeps the output-valid bit. It derives the
// almost-empty flag. Assumes the empty offset is quasi-static.
module dcf_rd_ctrl #(
    parameter int AW          = 8,
    parameter int W           = 18,
    parameter int SYNC_STAGES = 2,
    parameter bit PROG_REG    = 1'b1
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          ren,
    input  logic          fwft_sel,
    input  logic [AW:0]   wgray_in,
    input  logic [AW-1:0] ae_ofs,
    input  logic [W-1:0]  mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [W-1:0]  dout,
    output logic          ef_or,
    output logic          ae
);
    localparam int PW = AW + 1;

    logic [AW:0] rbin, wq, rcount;
    logic        ram_empty, fwft_r, ov, rd_do, ae_c;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rclk), .rst_n(rrst_n), .d(wgray_in), .q(wq)
    );

    assign ram_empty = (rgray == wq);
    assign rd_do     = ~ram_empty & (fwft_r ? (~ov | ren) : ren);
    assign raddr     = rbin[AW-1:0];
    assign rcount    = g2b(wq) - rbin;
    assign ae_c      = rcount <= {1'b0, ae_ofs};
    assign ef_or     = fwft_r ? ov : ram_empty;

    // Latch the timing mode while reset is held.
    always_ff @(posedge rclk) begin
        if (!rrst_n) fwft_r <= fwft_sel;
    end

    // Advance the read pointer and load the output word.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else if (rd_do) begin
            rbin  <= rbin + 1'b1;
            rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
            dout  <= mem_q;
        end
    end

    // Output-valid bit, used only in fall-through timing.
    always_ff @(posedge rclk) begin
        if (!rrst_n || !fwft_r) ov <= 1'b0;
        else if (rd_do)         ov <= 1'b1;
        else if (ren)           ov <= 1'b0;
    end

    generate
        if (PROG_REG) begin : g_reg
            // Register almost-empty in the read domain.
            always_ff @(posedge rclk) begin
                if (!rrst_n) ae <= 1'b1;
                else         ae <= ae_c;
            end
        end else begin : g_comb
            assign ae = ae_c;
        end
    endgenerate

    assert_empty_read_hold_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!fwft_r && ren && ef_or) |=> ($stable(dout) && $stable(rbin)));
    assert_ready_hold_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
        (fwft_r && ov && !ren) |=> (ov && $stable(dout)));
    assert_mode_stable_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        !$rose(rrst_n) |-> $stable(fwft_r));
endmodule

// File: rtl/dcfifo_pflag.sv
// Top level of the dual-clock FIFO with threshold flags. It connects the write
// control, the read control and the storage array. Assumes DEPTH is one of
// 256, 512, 1024, 2048, 4096 and that fwft_sel is held steady through reset.
module dcfifo_pflag #(
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2,
    parameter bit PROG_REG    = 1'b1,
    localparam int AW         = $clog2(DEPTH),
    localparam int W          = dcf_pkg::DATA_W
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wen,
    input  logic [W-1:0]  din,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          ren,
    output logic [W-1:0]  dout,
    input  logic          fwft_sel,
    input  logic          ofs_ld,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    output logic          ef_or,
    output logic          ff_ir,
    output logic          ae,
    output logic          af,
    output logic          hf
);
    logic          we;
    logic [AW-1:0] waddr, raddr, ae_ofs;
    logic [AW:0]   wgray, rgray;
    logic [W-1:0]  mem_q;

    dcf_wr_ctrl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES), .PROG_REG(PROG_REG)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .fwft_sel(fwft_sel),
        .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
        .rgray_in(rgray), .we(we), .waddr(waddr), .wgray(wgray),
        .ae_ofs(ae_ofs), .ff_ir(ff_ir), .hf(hf), .af(af)
    );

    dcf_mem #(.AW(AW), .W(W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_q)
    );

    dcf_rd_ctrl #(.AW(AW), .W(W), .SYNC_STAGES(SYNC_STAGES), .PROG_REG(PROG_REG)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .fwft_sel(fwft_sel),
        .wgray_in(wgray), .ae_ofs(ae_ofs), .mem_q(mem_q),
        .raddr(raddr), .rgray(rgray), .dout(dout), .ef_or(ef_or), .ae(ae)
    );
endmodule

// File: tb/tb_dcfifo_pflag.sv
// Self-checking bench for dcfifo_pflag. Both sides share one 50 MHz clock.
// A queue model predicts the data; settled flags are predicted from the model count.
module tb_dcfifo_pflag;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen = 1'b0, ren = 1'b0, fwft_sel = 1'b0;
    logic          ofs_ld = 1'b0, ofs_sel = 1'b0;
    logic [AW-1:0] ofs_val = '0;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic          ef_or, ff_ir, ae, af, hf;

    int          n_chk = 0, n_fail = 0;
    bit          fwft = 1'b0;
    int          ae_off = 7, af_off = 7;
    logic [17:0] q [$];

    always #10 clk = ~clk;

    dcfifo_pflag #(.DEPTH(DEPTH)) dut (
        .wclk(clk), .wrst_n(rst_n), .wen(wen), .din(din),
        .rclk(clk), .rrst_n(rst_n), .ren(ren), .dout(dout),
        .fwft_sel(fwft_sel), .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
        .ef_or(ef_or), .ff_ir(ff_ir), .ae(ae), .af(af), .hf(hf)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [17:0] rnd_word();
        return 18'($urandom);
    endfunction

    // One clock from negedge to negedge, with an optional write and/or read.
    task automatic step(input bit want_w, input bit want_r, input logic [17:0] wd,
                        input bit force_w, input bit force_r);
        bit space, avail, w, r, got;
        logic [17:0] exp;
        space = fwft ? (ff_ir === 1'b1) : (ff_ir === 1'b0);
        avail = fwft ? (ef_or === 1'b1) : (ef_or === 1'b0);
        w = want_w && (space || force_w);
        r = want_r && (avail || force_r);
        got = 1'b0;
        exp = '0;
        if (r && avail) begin
            if (q.size() == 0) check("R1", "data flagged with nothing stored", 1, 0);
            else begin
                exp = q.pop_front();
                got = 1'b1;
                if (fwft) check("R1", "fall-through data order", 32'(dout), 32'(exp));
            end
        end
        wen = w; din = wd; ren = r;
        if (w && space) q.push_back(wd);
        @(posedge clk); @(negedge clk);
        wen = 1'b0; ren = 1'b0;
        if (got && !fwft) check("R1", "read data order", 32'(dout), 32'(exp));
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic fill_to(input int target);
        int guard;
        guard = 0;
        while (q.size() != target && guard < 4000) begin
            step(q.size() < target, q.size() > target, rnd_word(), 1'b0, 1'b0);
            guard++;
        end
        if (guard >= 4000) check("R1", "fill did not reach target", q.size(), target);
    endtask

    // Let the flags settle, then compare every flag against the model count.
    task automatic chk_flags();
        int n, rc;
        idle(8);
        n  = q.size();
        rc = fwft ? ((n > 0) ? n - 1 : 0) : n;
        if (fwft) begin
            check("R5", "output ready", 32'(ef_or), 32'(n > 0));
            check("R5", "input ready", 32'(ff_ir), 32'(rc != DEPTH));
        end else begin
            check("R4", "empty", 32'(ef_or), 32'(n == 0));
            check("R4", "full", 32'(ff_ir), 32'(n == DEPTH));
        end
        check("R7", "half full", 32'(hf), 32'(rc > DEPTH / 2));
        check("R8", "almost empty", 32'(ae), 32'(rc <= ae_off));
        check("R9", "almost full", 32'(af), 32'(rc >= DEPTH - af_off));
    endtask

    task automatic load_ofs(input logic sel, input int val);
        ofs_ld = 1'b1; ofs_sel = sel; ofs_val = AW'(val);
        @(posedge clk); @(negedge clk);
        ofs_ld = 1'b0;
        if (sel) af_off = val; else ae_off = val;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0; fwft_sel = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        q.delete(); fwft = mode; ae_off = 7; af_off = 7;
        check("R11", "reset ef_or", 32'(ef_or), 32'(mode ? 0 : 1));
        check("R6", "mode shown on ff_ir", 32'(ff_ir), 32'(mode ? 1 : 0));
        check("R11", "reset hf", 32'(hf), 0);
        check("R11", "reset ae", 32'(ae), 1);
        check("R11", "reset af", 32'(af), 0);
    endtask

    task automatic random_mix(input int cycles, input int pw, input int pr);
        for (int i = 0; i < cycles; i++)
            step(($urandom % 100) < pw, ($urandom % 100) < pr, rnd_word(), 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [17:0] held;
        void'($urandom(32'd1234));

        // Standard timing.
        do_reset(1'b0);
        step(1'b1, 1'b0, 18'h15A5A, 1'b0, 1'b0);
        chk_flags();
        fill_to(0);
        chk_flags();
        held = dout;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, 1'b0, 1'b1);
        check("R3", "dout after read at empty", 32'(dout), 32'(held));
        chk_flags();
        step(1'b1, 1'b0, 18'h0C3C3, 1'b0, 1'b0);
        idle(4);
        step(1'b0, 1'b1, '0, 1'b0, 1'b0);      // R3: pointer must not have slipped
        fill_to(7);   chk_flags();             // R10 default empty offset
        fill_to(8);   chk_flags();
        fill_to(248); chk_flags();             // R10 default full offset
        fill_to(249); chk_flags();
        load_ofs(1'b0, 20);
        load_ofs(1'b1, 30);
        fill_to(21);  chk_flags();             // R8 boundary
        fill_to(20);  chk_flags();
        fill_to(128); chk_flags();             // R7 boundary
        fill_to(129); chk_flags();
        fill_to(225); chk_flags();             // R9 boundary
        fill_to(226); chk_flags();
        fill_to(DEPTH); chk_flags();
        step(1'b1, 1'b0, 18'h2AAAA, 1'b1, 1'b0); // R2 write at full
        chk_flags();
        fill_to(0); chk_flags();
        random_mix(3000, 70, 40);
        random_mix(3000, 40, 70);
        fill_to(0); chk_flags();

        // Fall-through timing.
        do_reset(1'b1);
        step(1'b1, 1'b0, 18'h3F00F, 1'b0, 1'b0);
        idle(6);
        check("R5", "ready without request", 32'(ef_or), 1);
        check("R5", "first word on dout", 32'(dout), 32'h3F00F);
        chk_flags();
        fill_to(0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, 1'b0, 1'b1);
        check("R5", "ready after read at empty", 32'(ef_or), 0);
        fill_to(8);   chk_flags();             // R10 defaults restored by reset
        fill_to(9);   chk_flags();
        fill_to(249); chk_flags();
        fill_to(250); chk_flags();
        fill_to(DEPTH + 1); chk_flags();
        step(1'b1, 1'b0, 18'h12345, 1'b1, 1'b0); // R2 write with no room
        chk_flags();
        fill_to(0); chk_flags();
        random_mix(3000, 70, 40);
        random_mix(3000, 40, 70);
        fill_to(0); chk_flags();

        finish_run();
    end
endmodule